// File: doc/BRIEF.md
# Arbiter-Tree Rule Reduction Network

This block compacts a wide, mostly empty vector of match flags into a few streams of rule identifiers. Each beat delivers one flag and one rule identifier per lane. The lanes are split evenly among the output ports. Each port is fed by its own tree of 4-input round-robin arbiters, and a small register FIFO sits at the output of every arbiter node. Every node moves at most one identifier per cycle toward the root. All the roots together can present one identifier on every output port in the same cycle.

Backpressure runs from the root toward the leaves. A node takes an item from a child only when its own FIFO has room. A FIFO that is full stops taking items, and the child keeps its item until space returns. The lanes of an accepted beat are held in registers until each pending lane has been granted. The next beat is accepted only after that.

A beat may be marked as the last of a packet. After such a beat is accepted, the input stays closed until the whole network is empty. Then a one-cycle end-of-packet pulse is raised, so identifiers from different packets never mix on the outputs. The block is used behind a pattern matcher that produces sparse hits, to feed a narrow downstream checker.

Top module: `rule_reduce_tree`

## Requirements
- R1: While reset is asserted, out_valid, out_eop and in_ready are all low. in_ready rises within three clock cycles after reset is released.
- R2: Every lane whose in_match bit is set in an accepted beat has its in_rule value appear exactly once on the outputs. The rule value of a lane whose match bit is clear never appears.
- R3: Output port p carries only identifiers from lanes p*32 to p*32+31 (default sizes: 256 lanes, 8 ports).
- R4: All 8 output ports can present a valid identifier in the same cycle.
- R5: Inside a port's group, lane 4j+k feeds input k of leaf arbiter j. Every arbiter's pointer is 0 after reset. The arbiter grants the first requesting input at or after its pointer, counting upward modulo 4. After a grant, the pointer moves to the granted input plus one, modulo 4.
- R6: While out_valid[p] is high and out_ready[p] is low, out_valid[p] stays high and out_rule[p] does not change on the next cycle. No identifier is lost however long the stall lasts.
- R7: A beat is taken only on a cycle where in_valid and in_ready are both high. in_ready stays low while any matched lane of the previous beat has not yet been granted.
- R8: After the beat carrying in_last is taken, out_eop pulses high for exactly one cycle. The pulse comes once every identifier of that packet has been handed over, and no out_valid is high during it. in_ready stays low from the cycle after that beat until the pulse cycle, inclusive. A last beat with no matches, sent into an idle network, gives the pulse in the first cycle after it is taken.
- R9: A beat taken without in_last never causes an end-of-packet pulse. A packet may span several beats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| in_valid | input | 1 | A beat of match flags is offered |
| in_ready | output | 1 | The block can take a beat this cycle |
| in_last | input | 1 | The offered beat closes a packet |
| in_match | input | LANES (256) | One match flag per lane |
| in_rule | input | LANES x RULE_W (256 x 16) | Rule identifier for each lane |
| out_valid | output | PORTS (8) | Identifier present on each output port |
| out_ready | input | PORTS (8) | Downstream accepts the identifier on each port |
| out_rule | output | PORTS x RULE_W (8 x 16) | Rule identifier on each output port |
| out_eop | output | 1 | One-cycle pulse: all identifiers of the closed packet have been delivered |

## Verification
Two events can land in the same cycle. An output handshake can be the one that empties the network, and in the next cycle the drain detection must raise the end-of-packet pulse. Separately, one FIFO can be popped by its parent while its child offers a new item. These overlaps are provoked by toggling out_ready at random on each port during multi-beat packets, including a full stall of every port with a dense beat. A scoreboard keyed by rule identifier judges the result. It requires the count of outstanding identifiers to be zero at each pulse, with no valid output during the pulse, no identifier seen twice, and each identifier on its own port. An ordered log on port 0 checks the arbiter rotation.

// File: rtl/rr_pkg.sv
package rr_pkg;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // number of arbiter nodes on tree level l for n leaves of radix r
  function automatic int lvl_width(input int n, input int r, input int l);
    int w;
    w = n;
    for (int i = 0; i <= l; i++) w = ceil_div(w, r);
    return w;
  endfunction

  function automatic int num_levels(input int n, input int r);
    int w;
    int l;
    w = n;
    l = 0;
    while (w > 1) begin
      w = ceil_div(w, r);
      l++;
    end
    return l;
  endfunction

  // index of the first node of level l in a flat node array
  function automatic int lvl_offset(input int n, input int r, input int l);
    int s;
    s = 0;
    for (int i = 0; i < l; i++) s += lvl_width(n, r, i);
    return s;
  endfunction

endpackage

// File: rtl/rr_fifo.sv
module rr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    full    = (cnt_q == CNT_FULL);
    empty   = (cnt_q == '0);
    do_push = push && !full;
    do_pop  = pop && !empty;
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    if (do_push) wp_d = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  assign pop_data = mem_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= push_data;
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full FIFO");

  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty) else $error("pop from empty FIFO");

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL) else $error("FIFO occupancy out of range");

endmodule

// File: rtl/rr_arb.sv
module rr_arb #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_any,
  output logic [IW-1:0] gnt_idx
);

  localparam logic [IW-1:0] IDX_LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q, ptr_d;

  // first requester at or after the pointer wins
  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int off = N - 1; off >= 0; off--) begin
      int s;
      s = int'(ptr_q) + off;
      if (s >= N) s = s - N;
      if (req[s]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(s);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (gnt_idx == IDX_LAST) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  a_r5_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && $past(adv) && (&req)) |-> (gnt_idx != $past(gnt_idx)))
    else $error("arbiter granted the same input twice under full load");

endmodule

// File: rtl/rr_node.sv
module rr_node #(
  parameter  int RADIX = 4,
  parameter  int W     = 16,
  parameter  int DEPTH = 2,
  localparam int IW    = (RADIX > 1) ? $clog2(RADIX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [RADIX-1:0]      in_valid,
  input  logic [RADIX-1:0][W-1:0] in_data,
  output logic [RADIX-1:0]      in_ready,
  output logic                  out_valid,
  output logic [W-1:0]          out_data,
  input  logic                  out_ready,
  output logic                  idle
);

  logic          gnt_any;
  logic [IW-1:0] gnt_idx;
  logic          fire, full, empty, pop;

  rr_arb #(.N(RADIX)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (in_valid),
    .adv     (fire),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  // take from a child only when the local FIFO has room
  always_comb begin
    fire     = gnt_any && !full;
    in_ready = '0;
    if (fire) in_ready[gnt_idx] = 1'b1;
  end

  assign pop = out_ready && !empty;

  rr_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (fire),
    .push_data (in_data[gnt_idx]),
    .full      (full),
    .pop       (pop),
    .pop_data  (out_data),
    .empty     (empty)
  );

  assign out_valid = !empty;
  assign idle      = empty;

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready)) else $error("more than one child popped");

  a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0) else $error("child popped without a request");

endmodule

// File: rtl/rr_subtree.sv
module rr_subtree #(
  parameter int LANES = 32,
  parameter int RADIX = 4,
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES-1:0][W-1:0] lane_data,
  output logic [LANES-1:0]        lane_ready,
  output logic                    out_valid,
  output logic [W-1:0]            out_data,
  input  logic                    out_ready,
  output logic                    idle
);

  localparam int NL = rr_pkg::num_levels(LANES, RADIX);
  localparam int TN = rr_pkg::lvl_offset(LANES, RADIX, NL);

  logic [TN-1:0]        node_valid;
  logic [TN-1:0][W-1:0] node_data;
  logic [TN-1:0]        node_ready;
  logic [TN-1:0]        node_idle;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int NW   = rr_pkg::lvl_width(LANES, RADIX, l);
    localparam int OFF  = rr_pkg::lvl_offset(LANES, RADIX, l);
    localparam int PW   = (l == 0) ? LANES : rr_pkg::lvl_width(LANES, RADIX, l - 1);
    localparam int POFF = (l == 0) ? 0 : rr_pkg::lvl_offset(LANES, RADIX, l - 1);

    for (genvar j = 0; j < NW; j++) begin : g_node
      logic [RADIX-1:0]        iv;
      logic [RADIX-1:0]        ir;
      logic [RADIX-1:0][W-1:0] id;

      for (genvar k = 0; k < RADIX; k++) begin : g_in
        localparam int SRC = j * RADIX + k;
        if (SRC < PW) begin : g_used
          if (l == 0) begin : g_leaf
            assign iv[k]           = lane_valid[SRC];
            assign id[k]           = lane_data[SRC];
            assign lane_ready[SRC] = ir[k];
          end else begin : g_inner
            assign iv[k]                 = node_valid[POFF+SRC];
            assign id[k]                 = node_data[POFF+SRC];
            assign node_ready[POFF+SRC]  = ir[k];
          end
        end else begin : g_pad
          assign iv[k] = 1'b0;
          assign id[k] = '0;
          a_r3_pad_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !ir[k]) else $error("padding input granted");
        end
      end

      rr_node #(.RADIX(RADIX), .W(W), .DEPTH(DEPTH)) u_node (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (iv),
        .in_data   (id),
        .in_ready  (ir),
        .out_valid (node_valid[OFF+j]),
        .out_data  (node_data[OFF+j]),
        .out_ready (node_ready[OFF+j]),
        .idle      (node_idle[OFF+j])
      );
    end
  end

  assign node_ready[TN-1] = out_ready;
  assign out_valid        = node_valid[TN-1];
  assign out_data         = node_data[TN-1];
  assign idle             = &node_idle;

endmodule

// File: rtl/rule_reduce_tree.sv
module rule_reduce_tree #(
  parameter int LANES  = 256,
  parameter int PORTS  = 8,
  parameter int RADIX  = 4,
  parameter int RULE_W = 16,
  parameter int DEPTH  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_last,
  input  logic [LANES-1:0]             in_match,
  input  logic [LANES-1:0][RULE_W-1:0] in_rule,
  output logic [PORTS-1:0]             out_valid,
  input  logic [PORTS-1:0]             out_ready,
  output logic [PORTS-1:0][RULE_W-1:0] out_rule,
  output logic                         out_eop
);

  localparam int LPP = LANES / PORTS;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LANES-1:0]             pend_q, pend_d;
  logic [LANES-1:0][RULE_W-1:0] rule_q;
  logic [LANES-1:0]             lane_ready;
  logic [PORTS-1:0]             sub_idle;
  logic                         drain_q, drain_d;
  logic                         accept, lanes_clear;

  always_comb begin
    lanes_clear = (pend_q == '0);
    in_ready    = rst_int_n && lanes_clear && !drain_q;
    accept      = in_valid && in_ready;
    out_eop     = drain_q && lanes_clear && (&sub_idle);
    pend_d      = accept ? in_match : (pend_q & ~lane_ready);
    drain_d     = drain_q;
    if (accept && in_last) drain_d = 1'b1;
    else if (out_eop)      drain_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      drain_q <= drain_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) rule_q <= in_rule;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    rr_subtree #(.LANES(LPP), .RADIX(RADIX), .W(RULE_W), .DEPTH(DEPTH)) u_tree (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .lane_valid (pend_q[p*LPP +: LPP]),
      .lane_data  (rule_q[p*LPP +: LPP]),
      .lane_ready (lane_ready[p*LPP +: LPP]),
      .out_valid  (out_valid[p]),
      .out_data   (out_rule[p]),
      .out_ready  (out_ready[p]),
      .idle       (sub_idle[p])
    );

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
      (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_rule[p])))
      else $error("stalled output changed");
  end

  a_r7_no_spurious_lane: assert property (@(posedge clk) disable iff (!rst_int_n)
    !accept |=> ((pend_q & ~$past(pend_q)) == '0))
    else $error("lane became pending without a taken beat");

  a_r8_eop_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_eop |-> (out_valid == '0)) else $error("output valid during end of packet");

  a_r8_eop_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_eop |=> !out_eop) else $error("end-of-packet pulse longer than one cycle");

  a_r9_no_early_eop: assert property (@(posedge clk) disable iff (!rst_int_n)
    (accept && !in_last) |=> !out_eop) else $error("end of packet after a non-last beat");

endmodule

// File: tb/tb_rule_reduce_tree.sv
`timescale 1ns/1ps
module tb_rule_reduce_tree;

  localparam int LANES  = 256;
  localparam int PORTS  = 8;
  localparam int RULE_W = 16;
  localparam int LPP    = LANES / PORTS;

  logic                         clk = 1'b0;
  logic                         rst_n;
  logic                         in_valid;
  logic                         in_ready;
  logic                         in_last;
  logic [LANES-1:0]             in_match;
  logic [LANES-1:0][RULE_W-1:0] in_rule;
  logic [PORTS-1:0]             out_valid;
  logic [PORTS-1:0]             out_ready;
  logic [PORTS-1:0][RULE_W-1:0] out_rule;
  logic                         out_eop;

  always #2.5 clk = ~clk;

  rule_reduce_tree dut (
    .clk, .rst_n, .in_valid, .in_ready, .in_last, .in_match, .in_rule,
    .out_valid, .out_ready, .out_rule, .out_eop
  );

  int checks = 0;
  int fails  = 0;
  int exp_cnt [int];
  int exp_port [int];
  int outstanding = 0;
  int id_ctr = 0;
  int pkts_sent = 0;
  int eop_seen = 0;
  bit draining_tb = 1'b0;
  bit all8_seen = 1'b0;
  bit done = 1'b0;
  int port0_log [$];
  logic [PORTS-1:0] rdy_mask = '1;
  bit rdy_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= rdy_rand ? (rdy_mask & lfsr[7:0]) : rdy_mask;
  end

  // monitor: samples 1 ns after the falling edge, handshake lands on next rising edge
  initial begin
    logic [PORTS-1:0]             stall_prev;
    logic [PORTS-1:0][RULE_W-1:0] rule_prev;
    stall_prev = '0;
    rule_prev  = '0;
    forever begin
      @(negedge clk);
      #1;
      if (!rst_n) continue;
      if (out_valid == '1) all8_seen = 1'b1;
      for (int p = 0; p < PORTS; p++) begin
        if (stall_prev[p]) begin
          check(out_valid[p] && out_rule[p] == rule_prev[p], "R6", "stalled port held",
                out_rule[p], rule_prev[p]);
        end
        if (out_valid[p] && out_ready[p]) begin
          int key;
          key = int'(out_rule[p]);
          if (!exp_cnt.exists(key) || exp_cnt[key] == 0) begin
            check(1'b0, "R2", "identifier unexpected or repeated", key, -1);
          end else begin
            exp_cnt[key]--;
            outstanding--;
            check(1'b1, "R2", "identifier delivered", key, key);
            check(exp_port[key] == p, "R3", "identifier on its own port", p, exp_port[key]);
          end
          if (p == 0) port0_log.push_back(key);
        end
        stall_prev[p] = out_valid[p] && !out_ready[p];
        rule_prev[p]  = out_rule[p];
      end
      if (draining_tb)
        check(in_ready == 1'b0, "R8", "input closed while packet drains", in_ready, 0);
      if (out_eop) begin
        check(draining_tb, "R9", "pulse only after a last beat", 1, draining_tb);
        check(outstanding == 0, "R8", "all identifiers out at pulse", outstanding, 0);
        check(out_valid == '0, "R8", "no valid during pulse", out_valid, 0);
        eop_seen++;
        draining_tb = 1'b0;
      end
    end
  end

  task automatic send_beat(input logic [LANES-1:0] m, input bit last);
    logic [LANES-1:0][RULE_W-1:0] r;
    bit idle_before;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        r[i] = RULE_W'(id_ctr & 16'h7fff);
        id_ctr++;
      end else begin
        r[i] = RULE_W'(16'h8000 | $urandom_range(0, 16'h7fff));
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_match = m;
    in_rule  = r;
    in_last  = last;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    idle_before = (outstanding == 0);
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        int key;
        key = int'(r[i]);
        if (exp_cnt.exists(key)) exp_cnt[key]++;
        else exp_cnt[key] = 1;
        exp_port[key] = i / LPP;
        outstanding++;
      end
    end
    if (last) begin
      draining_tb = 1'b1;
      pkts_sent++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    #1;
    if (m != '0)
      check(in_ready == 1'b0, "R7", "input closed while lanes pending", in_ready, 0);
    if (last && m == '0 && idle_before)
      check(out_eop == 1'b1, "R8", "empty last beat pulses next cycle", out_eop, 1);
  endtask

  task automatic wait_drain();
    while (eop_seen < pkts_sent) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [LANES-1:0] rand_lanes(input int one_in);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = ($urandom_range(0, one_in - 1) == 0);
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_match = '0;
    in_rule  = '0;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R1", "in_ready low in reset", in_ready, 0);
    check(out_valid == '0, "R1", "out_valid low in reset", out_valid, 0);
    check(out_eop == 1'b0, "R1", "out_eop low in reset", out_eop, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b1, "R1", "in_ready after release", in_ready, 1);
    check(out_valid == '0, "R1", "out_valid after release", out_valid, 0);

    // R5: lane 1 alone, then lanes 0 and 3: rotation gives 3 before 0
    port0_log.delete();
    base = id_ctr;
    send_beat(LANES'(1) << 1, 1'b0);
    send_beat((LANES'(1) << 0) | (LANES'(1) << 3), 1'b1);
    wait_drain();
    check(port0_log.size() == 3, "R5", "port 0 count", port0_log.size(), 3);
    if (port0_log.size() == 3) begin
      check(port0_log[0] == base,     "R5", "first grant", port0_log[0], base);
      check(port0_log[1] == base + 2, "R5", "second grant after pointer move", port0_log[1], base + 2);
      check(port0_log[2] == base + 1, "R5", "third grant wraps", port0_log[2], base + 1);
    end

    // R8: empty closing beat into an idle network
    send_beat('0, 1'b1);
    wait_drain();

    // R4: every lane set, all ports ready
    all8_seen = 1'b0;
    send_beat('1, 1'b1);
    wait_drain();
    check(all8_seen, "R4", "all ports valid together", all8_seen, 1);

    // R6: full stall of every port with a dense beat
    rdy_mask = '0;
    send_beat('1, 1'b1);
    repeat (30) @(negedge clk);
    rdy_mask = '1;
    wait_drain();

    // R9: multi-beat packet under random backpressure
    rdy_rand = 1'b1;
    for (int b = 0; b < 4; b++) send_beat(rand_lanes(8), b == 3);
    wait_drain();
    check(eop_seen == pkts_sent, "R9", "one pulse per packet", eop_seen, pkts_sent);

    // mixed packets of varied density
    for (int k = 0; k < 20; k++) begin
      int nb;
      nb = $urandom_range(1, 3);
      for (int b = 0; b < nb; b++) begin
        case ((k + b) % 4)
          0: send_beat(rand_lanes(2), b == nb - 1);
          1: send_beat(rand_lanes(16), b == nb - 1);
          2: send_beat(LANES'(1) << $urandom_range(0, LANES - 1), b == nb - 1);
          default: send_beat('0, b == nb - 1);
        endcase
      end
    end
    wait_drain();
    rdy_rand = 1'b0;
    repeat (5) @(negedge clk);

    check(outstanding == 0, "R2", "nothing lost at end", outstanding, 0);
    check(eop_seen == pkts_sent, "R8", "pulses equal packets", eop_seen, pkts_sent);
    check(in_ready == 1'b1, "R7", "input open when idle", in_ready, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule